// File: doc/BRIEF.md
# General-Purpose Event Status and Enable Bank

This block holds a small bank of general-purpose event bytes behind one byte-wide access window of `LEN` addresses. The lower half of the window holds status bytes and the upper half holds the matching enable bytes. Software clears status bits by writing ones to them and loads enable bytes by writing them directly. Hardware event sources raise bits in status byte 0 through an event mask input.

The block drives a pending flag that is high whenever status byte 0 and enable byte 0 have at least one set bit in common. The interrupt logic that follows uses this flag. Status and enable bytes above index 0 can be read and written, but they never affect the pending flag. An access outside the window is flagged for one cycle and does nothing else.

Top module: `gpe_bank_top`

## Requirements
- R1: With `HALF = LEN/2`, an address below `HALF` selects status byte `[addr]`, and an address from `HALF` to `LEN-1` selects enable byte `[addr-HALF]`. `acc_rdata` shows the selected byte combinationally in the same cycle as `acc_addr`, whether or not `acc_valid` is high.
- R2: A write (`acc_valid`=1, `acc_write`=1) to a status address clears each bit of that status byte where `acc_wdata` holds a 1 and leaves the other bits unchanged. The result is visible from the next cycle.
- R3: A write to an enable address replaces that enable byte with `acc_wdata`, visible from the next cycle.
- R4: Each 1 bit of `evt_set` sets the same bit of status byte 0 on the next clock edge. No other status byte is changed by events.
- R5: When a status write to byte 0 and an event arrive in the same cycle, the bits in `evt_set` end up set, even if the write would clear them.
- R6: `gpe_pending` is 1 exactly when (status byte 0 AND enable byte 0) is nonzero. Status and enable bytes at other indices have no effect on it.
- R7: An access with `acc_valid`=1 and `acc_addr` >= `LEN` is illegal. `acc_rdata` is 0 for such an address, a write to it changes no byte, and `acc_err` is 1 in the cycle after each illegal access and 0 otherwise.
- R8: Reset (`rst_n`=0, asynchronous) clears every status and enable byte, so that all reads return 0, and drives `gpe_pending` and `acc_err` to 0.
- R9: With `acc_valid`=0, no byte changes, whatever the values on `acc_write`, `acc_addr` and `acc_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address in the window |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Byte at the current address, 0 if outside the window |
| acc_err | output | 1 | One-cycle pulse after an illegal access |
| evt_set | input | 8 | Event mask ORed into status byte 0 |
| gpe_pending | output | 1 | Status byte 0 AND enable byte 0 is nonzero |

## Verification
The assertions assume that `acc_addr` is wide enough to express addresses at and above `LEN`. The assertion on events also assumes that `evt_set` is driven to a known value on every cycle out of reset. The stimulus changes all inputs only on the falling clock edge and keeps them fully defined. It drives events together with status writes, and drives illegal addresses both back to back and mixed with legal accesses, so that the priority of event over clear and the spacing of the error pulse are both exercised.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RGN_STATUS  = 2'd0,
        RGN_ENABLE  = 2'd1,
        RGN_ILLEGAL = 2'd2
    } gpe_rgn_e;
endpackage

// File: rtl/gpe_addr_dec.sv
module gpe_addr_dec
    import gpe_pkg::*;
#(
    parameter int LEN    = 4,
    parameter int ADDR_W = 4,
    localparam int HALF  = LEN / 2,
    localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output gpe_rgn_e          rgn,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] en_off;

    always_comb begin
        en_off = addr - ADDR_W'(HALF);
        if (addr < ADDR_W'(HALF)) begin
            rgn = RGN_STATUS;
            idx = addr[IDX_W-1:0];
        end else if (addr < ADDR_W'(LEN)) begin
            rgn = RGN_ENABLE;
            idx = en_off[IDX_W-1:0];
        end else begin
            rgn = RGN_ILLEGAL;
            idx = '0;
        end
    end
endmodule

// File: rtl/gpe_bank.sv
module gpe_bank
    import gpe_pkg::*;
#(
    parameter int HALF   = 2,
    parameter int IDX_W  = 1,
    localparam int FLAT_W = HALF * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sts_wr,
    input  logic              en_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] evt,
    input  logic              bad_acc,
    output logic [FLAT_W-1:0] sts_o,
    output logic [FLAT_W-1:0] en_o,
    output logic              err_o,
    output logic              pending_o
);
    typedef struct packed {
        logic [HALF-1:0][BYTE_W-1:0] sts;
        logic [HALF-1:0][BYTE_W-1:0] en;
        logic                        err;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sts_wr) begin
            s_d.sts[idx] = s_q.sts[idx] & ~wdata;
        end
        if (en_wr) begin
            s_d.en[idx] = wdata;
        end
        // events are applied after the clear, so they win on byte 0
        s_d.sts[0] = s_d.sts[0] | evt;
        s_d.err    = bad_acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < HALF; g++) begin : g_flat
        assign sts_o[g*BYTE_W +: BYTE_W] = s_q.sts[g];
        assign en_o[g*BYTE_W +: BYTE_W]  = s_q.en[g];
    end

    assign err_o     = s_q.err;
    assign pending_o = |(s_q.sts[0] & s_q.en[0]);

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && evt == '0) |=> s_q.sts[$past(idx)] == ($past(s_q.sts[idx]) & ~$past(wdata))); // R2
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> s_q.en[$past(idx)] == $past(wdata)); // R3
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> (s_q.sts[0] & $past(evt)) == $past(evt)); // R5
    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> ($past(evt) != '0 || $past(en_wr))); // R6
endmodule

// File: rtl/gpe_bank_top.sv
module gpe_bank_top
    import gpe_pkg::*;
#(
    parameter int LEN    = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              acc_err,
    input  logic [7:0]        evt_set,
    output logic              gpe_pending
);
    localparam int HALF   = LEN / 2;
    localparam int IDX_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int FLAT_W = HALF * BYTE_W;

    gpe_rgn_e          rgn;
    logic [IDX_W-1:0]  idx;
    logic [FLAT_W-1:0] sts_flat;
    logic [FLAT_W-1:0] en_flat;
    logic              sts_wr, en_wr, bad_acc;

    gpe_addr_dec #(.LEN(LEN), .ADDR_W(ADDR_W)) u_dec (
        .addr (acc_addr),
        .rgn  (rgn),
        .idx  (idx)
    );

    always_comb begin
        sts_wr  = acc_valid && acc_write && (rgn == RGN_STATUS);
        en_wr   = acc_valid && acc_write && (rgn == RGN_ENABLE);
        bad_acc = acc_valid && (rgn == RGN_ILLEGAL);
        case (rgn)
            RGN_STATUS: acc_rdata = sts_flat[int'(idx)*BYTE_W +: BYTE_W];
            RGN_ENABLE: acc_rdata = en_flat[int'(idx)*BYTE_W +: BYTE_W];
            default:    acc_rdata = '0;
        endcase
    end

    gpe_bank #(.HALF(HALF), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sts_wr    (sts_wr),
        .en_wr     (en_wr),
        .idx       (idx),
        .wdata     (acc_wdata),
        .evt       (evt_set),
        .bad_acc   (bad_acc),
        .sts_o     (sts_flat),
        .en_o      (en_flat),
        .err_o     (acc_err),
        .pending_o (gpe_pending)
    );

    AST_BAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr >= ADDR_W'(LEN)) |=> acc_err); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(acc_valid && acc_addr >= ADDR_W'(LEN))); // R7
    AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr >= ADDR_W'(LEN)) |-> acc_rdata == 8'h00); // R7
    AST_BAD_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr >= ADDR_W'(LEN)) |=> $stable(en_flat)); // R7
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && evt_set == 8'h00) |=> ($stable(en_flat) && $stable(sts_flat))); // R9
endmodule

// File: tb/test_gpe_bank_top.sv
`timescale 1ns/1ps
module test_gpe_bank_top;
    localparam int LEN    = 4;
    localparam int ADDR_W = 4;
    localparam int HALF   = LEN / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [7:0]        acc_wdata = '0;
    logic [7:0]        acc_rdata;
    logic              acc_err;
    logic [7:0]        evt_set = '0;
    logic              gpe_pending;

    int checks = 0;
    int fails  = 0;

    int sts_m [HALF];
    int en_m  [HALF];
    bit err_m;

    always #2.5 clk = ~clk;

    gpe_bank_top #(.LEN(LEN), .ADDR_W(ADDR_W)) i_gpe_bank_top (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_err(acc_err), .evt_set(evt_set), .gpe_pending(gpe_pending)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HALF; i++) begin
                sts_m[i] = 0;
                en_m[i]  = 0;
            end
            err_m = 1'b0;
        end else begin
            if (acc_valid && acc_write) begin
                if (int'(acc_addr) < HALF)
                    sts_m[acc_addr] = sts_m[acc_addr] & ~int'(acc_wdata) & 8'hFF;
                else if (int'(acc_addr) < LEN)
                    en_m[int'(acc_addr) - HALF] = int'(acc_wdata);
            end
            sts_m[0] = sts_m[0] | int'(evt_set);
            err_m = acc_valid && (int'(acc_addr) >= LEN);
        end
    end

    function automatic int exp_read(int a);
        if (a < HALF) return sts_m[a];
        if (a < LEN)  return en_m[a - HALF];
        return 0;
    endfunction

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic step(string tag, bit v, bit w, int a, int wd, int ev);
        @(negedge clk);
        acc_valid = v;
        acc_write = w;
        acc_addr  = ADDR_W'(a);
        acc_wdata = 8'(wd);
        evt_set   = 8'(ev);
        #1;
        check(tag, "rdata", int'(acc_rdata), exp_read(a));
        check("R6", "pending", int'(gpe_pending), ((sts_m[0] & en_m[0]) != 0) ? 1 : 0);
        check("R7", "err", int'(acc_err), int'(err_m));
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < LEN; a++) step(tag, 1'b0, 1'b0, a, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; evt_set = '0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_all("R8");
        // enable loads
        step("R3", 1, 1, 2, 'hA5, 0);
        step("R3", 1, 0, 2, 0, 0);
        step("R3", 1, 1, 3, 'h3C, 0);
        step("R3", 1, 0, 3, 0, 0);
        step("R3", 1, 1, 2, 'h5A, 0);
        step("R3", 1, 0, 2, 0, 0);
        // events into byte 0 only
        step("R4", 0, 0, 0, 0, 'h82);
        step("R4", 0, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 0, 0);
        check("R6", "pending after event", int'(gpe_pending), 1);
        // write one to clear
        step("R2", 1, 1, 0, 'h02, 0);
        step("R2", 1, 0, 0, 0, 0);
        check("R2", "status0 after clear", int'(acc_rdata), 'h80);
        step("R2", 1, 1, 0, 'h00, 0);
        step("R2", 1, 0, 0, 0, 0);
        // event and clear together
        step("R5", 1, 1, 0, 'h81, 'h01);
        step("R5", 1, 0, 0, 0, 0);
        check("R5", "status0 event wins", int'(acc_rdata), 'h01);
        // pending depends only on byte 0
        step("R6", 1, 1, 2, 'h00, 0);
        step("R6", 1, 1, 3, 'hFF, 0);
        step("R6", 0, 0, 3, 0, 0);
        check("R6", "pending with only byte1 enable", int'(gpe_pending), 0);
        step("R6", 1, 1, 2, 'h01, 0);
        step("R6", 0, 0, 2, 0, 0);
        check("R6", "pending with byte0 enable", int'(gpe_pending), 1);
        // illegal accesses
        step("R7", 1, 0, 4, 0, 0);
        step("R7", 1, 1, 5, 'hFF, 0);
        step("R7", 1, 0, 15, 0, 0);
        step("R7", 0, 0, 9, 0, 0);
        step("R7", 1, 0, 2, 0, 0);
        check("R7", "enable0 after illegal write", int'(acc_rdata), 'h01);
        step("R7", 1, 0, 3, 0, 0);
        // no access without strobe
        step("R9", 0, 1, 2, 'hEE, 0);
        step("R9", 0, 1, 0, 'hFF, 0);
        step("R9", 0, 0, 2, 0, 0);
        check("R9", "enable0 unchanged", int'(acc_rdata), 'h01);
        step("R9", 0, 0, 0, 0, 0);
        check("R9", "status0 unchanged", int'(acc_rdata), 'h01);
        // mixed pattern sweep
        lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R1", lfsr[0], lfsr[1], int'(lfsr[5:2]) % 7, int'(lfsr[15:8]),
                 lfsr[6] ? int'(lfsr[12:9]) << lfsr[3:2] : 0);
        end
        // reset again with state present
        step("R8", 1, 1, 2, 'hFF, 'hFF);
        do_reset();
        read_all("R8");
        check("R8", "pending after reset", int'(gpe_pending), 0);
        check("R8", "err after reset", int'(acc_err), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule